// File: doc/BRIEF.md
# Bisync Receiver with Programmable Sync

This block is the receive half of a byte-synchronous serial channel. It takes a serial data bit and a bit-clock enable, both already produced by clock recovery, and hunts for a sync pattern whose length is set at run time to any value from 2 to 16 bits. When the pattern is seen it declares sync, aligns character boundaries to the bit that follows the pattern, and assembles characters of 1 to 8 bits.

When stripping is on, a character whose completion makes the recent bits equal the sync pattern is removed from the data stream. Removed characters are also kept out of the frame check. The frame check is a serial CRC that is 16 or 32 bits wide, preset by a start-of-block strobe. A residue flag reports a good frame once the received check bytes have been accumulated.

Top module: `bsync_rx`

## Requirements
- R1: After reset, in_sync_o, char_valid_o and crc_ok_o are all low and the block is hunting.
- R2: While hunting, each enabled bit is shifted into a comparison register. The last received bit lands at position 0, so pattern bit (length-1) is matched by the earliest of the compared bits. in_sync_o rises in the clock after the bit_en_i cycle of the bit that completes a match, and not before.
- R3: Only the low sync_len_i bits are compared. The length takes effect between 2 and 16: values below 2 act as 2 and values above 16 act as 16.
- R4: Character assembly starts with the bit after the matching bit. The first received bit becomes char_o bit 0, and the unused upper bits are zero. The length is char_len_i from 1 to 8, and 0 or 9..15 act as 8.
- R5: char_valid_o pulses high, with char_o, in the clock after the bit_en_i cycle of the last bit of a character, and only while in sync.
- R6: With strip_en_i high, a character whose last bit makes the comparison register match the pattern is not delivered. With strip_en_i low it is delivered like any other character.
- R7: A hunt_i pulse clears in_sync_o in the next clock, clears the comparison register and any partial character, and overrides a bit_en_i in the same cycle. No character is delivered while hunting.
- R8: With crc32_sel_i low, the CRC is x^16+x^12+x^5+1, reflected, with all-ones preset. Each bit is taken in receive order. crc_ok_o is high once data followed by its complemented CRC (low byte first, LSB first) has been received, which is when the register equals 0xF0B8.
- R9: With crc32_sel_i high, the CRC is the 32-bit Ethernet polynomial, reflected, with all-ones preset and good residue 0xDEBB20E3. Frames are framed the same way as in R8.
- R10: blk_start_i presets the CRC, so crc_ok_o is low in the next clock.
- R11: With stripping on, stripped characters leave the CRC untouched. With stripping off, sync characters are accumulated like data.
- R12: Cycles with bit_en_i low change neither the hunt, the assembly nor the CRC, whatever rxd_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Recovered bit-clock enable |
| rxd_i | input | 1 | Serial data bit |
| hunt_i | input | 1 | Drop sync and restart the hunt |
| blk_start_i | input | 1 | Preset the CRC |
| sync_len_i | input | 5 | Sync pattern length in bits |
| sync_pat_i | input | 16 | Sync pattern, right-justified |
| char_len_i | input | 4 | Character length in bits |
| strip_en_i | input | 1 | Remove sync characters from data and CRC |
| crc32_sel_i | input | 1 | 1 selects the 32-bit CRC, 0 the 16-bit CRC |
| char_o | output | 8 | Assembled character |
| char_valid_o | output | 1 | Character strobe |
| in_sync_o | output | 1 | Sync found |
| crc_ok_o | output | 1 | CRC register holds the good residue |

## Verification
Every result is due one clock after the bit_en_i cycle of the bit that decides it. That holds for in_sync_o rising on the last pattern bit, for char_valid_o with char_o on the last character bit, and for crc_ok_o, which follows the committed CRC register updated at that same edge. hunt_i and blk_start_i act one clock after their pulse. The bench drives every input at a falling edge and holds bit_en_i for one cycle. It samples outputs at the next falling edge, which is exactly half a period after the edge on which each result appears. A scoreboard queue is filled in send order, so a late, early, missing or extra character is reported at the falling edge on which the strobe is seen.

// File: rtl/bsync_pkg.sv
package bsync_pkg;
  localparam logic [15:0] CRC16_POLY = 16'h8408;
  localparam logic [15:0] CRC16_GOOD = 16'hF0B8;
  localparam logic [31:0] CRC32_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC32_GOOD = 32'hDEBB20E3;
endpackage

// File: rtl/bsync_hunt.sv
module bsync_hunt #(
  parameter int SYNC_MAX = 16,
  parameter int SLW = $clog2(SYNC_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                shift_i,
  input  logic                bit_i,
  input  logic [SLW-1:0]      len_i,
  input  logic [SYNC_MAX-1:0] pat_i,
  output logic                match_o
);
  logic [SYNC_MAX-2:0] sreg_q;
  logic [SYNC_MAX-1:0] shift_nxt, mask;

  assign shift_nxt = {sreg_q, bit_i};

  always_comb begin
    for (int i = 0; i < SYNC_MAX; i++) mask[i] = (int'(len_i) > i);
  end

  // match against the register value including the current bit
  assign match_o = shift_i && (((shift_nxt ^ pat_i) & mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sreg_q <= '0;
    else if (clear_i) sreg_q <= '0;
    else if (shift_i) sreg_q <= shift_nxt[SYNC_MAX-2:0];
  end
endmodule

// File: rtl/bsync_asm.sv
module bsync_asm #(
  parameter int CHAR_MAX = 8,
  parameter int CLW = $clog2(CHAR_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                step_i,
  input  logic                bit_i,
  input  logic [CLW-1:0]      len_i,
  output logic                last_o,
  output logic [CHAR_MAX-1:0] data_o
);
  logic [CLW-1:0]      cnt_q;
  logic [CHAR_MAX-1:0] acc_q;

  assign data_o = acc_q | (CHAR_MAX'(bit_i) << cnt_q);
  assign last_o = step_i && (cnt_q == len_i - CLW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (clear_i || last_o) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + CLW'(1);
      acc_q <= data_o;
    end
  end
endmodule

// File: rtl/bsync_crc_lane.sv
module bsync_crc_lane #(
  parameter int             W    = 16,
  parameter logic [W-1:0]   POLY = '0,
  parameter logic [W-1:0]   GOOD = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic step_i,
  input  logic bit_i,
  input  logic commit_i,
  input  logic revert_i,
  output logic ok_o
);
  logic [W-1:0] work_q, keep_q, work_nxt, stepped;

  assign stepped  = (work_q >> 1) ^ ((work_q[0] ^ bit_i) ? POLY : '0);
  assign work_nxt = step_i ? stepped : work_q;
  assign ok_o     = (keep_q == GOOD);

  // work accumulates the open character; keep holds the last accepted boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      work_q <= '1;
      keep_q <= '1;
    end else if (init_i) begin
      work_q <= '1;
      keep_q <= '1;
    end else begin
      work_q <= revert_i ? keep_q : work_nxt;
      if (commit_i) keep_q <= work_nxt;
    end
  end
endmodule

// File: rtl/bsync_rx.sv
module bsync_rx
  import bsync_pkg::*;
#(
  parameter int SYNC_MAX = 16,
  parameter int CHAR_MAX = 8,
  parameter int SLW = $clog2(SYNC_MAX + 1),
  parameter int CLW = $clog2(CHAR_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_en_i,
  input  logic                rxd_i,
  input  logic                hunt_i,
  input  logic                blk_start_i,
  input  logic [SLW-1:0]      sync_len_i,
  input  logic [SYNC_MAX-1:0] sync_pat_i,
  input  logic [CLW-1:0]      char_len_i,
  input  logic                strip_en_i,
  input  logic                crc32_sel_i,
  output logic [CHAR_MAX-1:0] char_o,
  output logic                char_valid_o,
  output logic                in_sync_o,
  output logic                crc_ok_o
);
  localparam int NLANE = 2;

  logic [SLW-1:0]      sync_eff;
  logic [CLW-1:0]      char_eff;
  logic                bit_ok, match, found, sync_step, char_end, drop, accept;
  logic [CHAR_MAX-1:0] asm_data;
  logic                in_sync_q, valid_q;
  logic [CHAR_MAX-1:0] char_q;
  logic [NLANE-1:0]    lane_ok;

  always_comb begin
    if (sync_len_i < SLW'(2))              sync_eff = SLW'(2);
    else if (sync_len_i > SLW'(SYNC_MAX))  sync_eff = SLW'(SYNC_MAX);
    else                                   sync_eff = sync_len_i;
    if (char_len_i == '0 || char_len_i > CLW'(CHAR_MAX)) char_eff = CLW'(CHAR_MAX);
    else                                                  char_eff = char_len_i;
  end

  // hunt wins over a bit in the same cycle
  assign bit_ok    = bit_en_i && !hunt_i;
  assign found     = bit_ok && !in_sync_q && match;
  assign sync_step = bit_ok && in_sync_q;
  assign drop      = char_end && strip_en_i && match;
  assign accept    = char_end && !drop;

  bsync_hunt #(.SYNC_MAX(SYNC_MAX), .SLW(SLW)) u_hunt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (hunt_i),
    .shift_i (bit_ok),
    .bit_i   (rxd_i),
    .len_i   (sync_eff),
    .pat_i   (sync_pat_i),
    .match_o (match)
  );

  bsync_asm #(.CHAR_MAX(CHAR_MAX), .CLW(CLW)) u_asm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (hunt_i),
    .step_i  (sync_step),
    .bit_i   (rxd_i),
    .len_i   (char_eff),
    .last_o  (char_end),
    .data_o  (asm_data)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int W = (g == 0) ? 16 : 32;
    localparam logic [W-1:0] POLY = (g == 0) ? W'(CRC16_POLY) : W'(CRC32_POLY);
    localparam logic [W-1:0] GOOD = (g == 0) ? W'(CRC16_GOOD) : W'(CRC32_GOOD);
    bsync_crc_lane #(.W(W), .POLY(POLY), .GOOD(GOOD)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .init_i   (blk_start_i),
      .step_i   (sync_step),
      .bit_i    (rxd_i),
      .commit_i (accept),
      .revert_i (drop),
      .ok_o     (lane_ok[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_sync_q <= 1'b0;
      valid_q   <= 1'b0;
      char_q    <= '0;
    end else begin
      if (hunt_i)     in_sync_q <= 1'b0;
      else if (found) in_sync_q <= 1'b1;
      valid_q <= accept;
      if (accept) char_q <= asm_data;
    end
  end

  assign char_o       = char_q;
  assign char_valid_o = valid_q;
  assign in_sync_o    = in_sync_q;
  assign crc_ok_o     = crc32_sel_i ? lane_ok[1] : lane_ok[0];
endmodule

// File: rtl/bsync_rx_chk.sv
module bsync_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_en_i,
  input logic hunt_i,
  input logic blk_start_i,
  input logic char_valid_o,
  input logic in_sync_o,
  input logic crc_ok_o
);
  assert_rise_on_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_sync_o) |-> ($past(bit_en_i) && !$past(hunt_i)));

  assert_char_in_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |-> in_sync_o);

  assert_hunt_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hunt_i |=> !in_sync_o);

  assert_sync_lost_by_hunt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_sync_o) |-> $past(hunt_i));

  assert_preset_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_start_i |=> !crc_ok_o);

  assert_char_needs_bit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |-> $past(bit_en_i));
endmodule

bind bsync_rx bsync_rx_chk u_chk (.*);

// File: tb/tb_bsync_rx.sv
module tb_bsync_rx;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_en_i = 1'b0, rxd_i = 1'b0, hunt_i = 1'b0, blk_start_i = 1'b0;
  logic [4:0] sync_len_i = 5'd8;
  logic [15:0] sync_pat_i = 16'h0016;
  logic [3:0] char_len_i = 4'd8;
  logic       strip_en_i = 1'b0, crc32_sel_i = 1'b0;
  logic [7:0] char_o;
  logic       char_valid_o, in_sync_o, crc_ok_o;

  always #2 clk_i = ~clk_i;

  bsync_rx dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  bit done = 0;

  task automatic check(input bit cond, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk_i) begin
    if (rst_ni && char_valid_o) begin
      if (exp_q.size() == 0) check(0, "R6/R7", "unexpected character", char_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(char_o == e, "R4/R5", "character", char_o, e);
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk_i); rxd_i = b; bit_en_i = 1'b1;
    @(negedge clk_i); bit_en_i = 1'b0; rxd_i = ~b;  // ignored bit (R12)
  endtask

  task automatic send_sync(input logic [15:0] p, input int len);
    for (int i = len - 1; i >= 0; i--) send_bit(p[i]);
  endtask

  task automatic send_char(input logic [7:0] c, input int len, input bit push);
    if (push) exp_q.push_back(c & 8'((1 << len) - 1));
    for (int i = 0; i < len; i++) send_bit(c[i]);
  endtask

  task automatic send_bytes(input logic [7:0] d[$]);
    foreach (d[k]) send_char(d[k], 8, 1);
  endtask

  task automatic pulse_hunt();
    @(negedge clk_i); hunt_i = 1'b1;
    @(negedge clk_i); hunt_i = 1'b0;
  endtask

  task automatic pulse_blk();
    @(negedge clk_i); blk_start_i = 1'b1;
    @(negedge clk_i); blk_start_i = 1'b0;
  endtask

  function automatic logic [31:0] crc_of(input logic [7:0] d[$], input bit wide);
    logic [31:0] c, poly;
    c    = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    poly = wide ? 32'hEDB8_8320 : 32'h0000_8408;
    foreach (d[k])
      for (int i = 0; i < 8; i++) begin
        logic fb;
        fb = c[0] ^ d[k][i];
        c  = c >> 1;
        if (fb) c = c ^ poly;
      end
    return c;
  endfunction

  function automatic void fcs_of(input logic [7:0] d[$], input bit wide,
                                 output logic [7:0] f[$]);
    logic [31:0] c;
    c = ~crc_of(d, wide);
    f = {};
    for (int i = 0; i < (wide ? 4 : 2); i++) f.push_back(c[8*i +: 8]);
  endfunction

  // pick a data set whose check bytes never look like the sync character
  task automatic pick_frame(input bit wide, output logic [7:0] d[$], output logic [7:0] f[$]);
    for (int s = 0; s < 256; s++) begin
      bit clash;
      d = {8'h31, 8'h32, 8'(8'h40 + s), 8'h34};
      fcs_of(d, wide, f);
      clash = (d[2] == 8'h68);
      foreach (f[k]) if (f[k] == 8'h68) clash = 1;
      if (!clash) break;
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      check(0, "watchdog", "timeout", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [7:0] d[$], f[$], dm[$];
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!in_sync_o, "R1", "in_sync after reset", in_sync_o, 0);
    check(!char_valid_o, "R1", "char_valid after reset", char_valid_o, 0);
    check(!crc_ok_o, "R1", "crc_ok after reset", crc_ok_o, 0);

    // R2: 8-bit pattern, sync only on the last bit
    send_bit(1); send_bit(1); send_bit(1);
    for (int i = 7; i >= 1; i--) send_bit(sync_pat_i[i]);
    check(!in_sync_o, "R2", "in_sync before last pattern bit", in_sync_o, 0);
    send_bit(sync_pat_i[0]);
    check(in_sync_o, "R2", "in_sync after pattern", in_sync_o, 1);

    // R4 R5 R12: characters LSB-first
    send_char(8'hA5, 8, 1);
    send_char(8'h3C, 8, 1);
    // R6: sync character delivered when not stripping, bit-reversed into char_o
    send_sync(16'h0016, 8); exp_q.push_back(8'h68);
    send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    send_bit(1); send_bit(0); send_bit(0); send_bit(1);
    exp_q.push_back(8'h96);
    strip_en_i = 1'b1;
    send_sync(16'h0016, 8);           // R6: stripped
    send_char(8'h5A, 8, 1);
    repeat (2) @(negedge clk_i);
    check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
    strip_en_i = 1'b0;

    // R7: hunt clears sync, nothing delivered while hunting
    pulse_hunt();
    check(!in_sync_o, "R7", "in_sync after hunt", in_sync_o, 1'b0);
    send_char(8'hA5, 8, 0);
    check(!in_sync_o, "R7", "still hunting", in_sync_o, 0);
    send_sync(16'h0016, 8);
    check(in_sync_o, "R2", "resync", in_sync_o, 1);
    @(negedge clk_i); hunt_i = 1'b1; bit_en_i = 1'b1; rxd_i = 1'b1;
    @(negedge clk_i); hunt_i = 1'b0; bit_en_i = 1'b0;
    check(!in_sync_o, "R7", "hunt beats bit_en", in_sync_o, 0);

    // R3 R4: 12-bit pattern, short characters
    sync_len_i = 5'd12; sync_pat_i = 16'h0ABC; char_len_i = 4'd5;
    send_bit(0); send_bit(0);
    send_sync(16'h0ABC, 12);
    check(in_sync_o, "R3", "12-bit sync", in_sync_o, 1);
    send_char(8'h1F, 5, 1);
    send_char(8'h0A, 5, 1);
    char_len_i = 4'd3;
    send_char(8'h05, 3, 1);
    char_len_i = 4'd0;                 // R4: acts as 8
    send_char(8'hC3, 8, 1);
    char_len_i = 4'd1;
    send_char(8'h01, 1, 1);
    char_len_i = 4'd8;

    // R3: 16-bit pattern
    pulse_hunt();
    sync_len_i = 5'd16; sync_pat_i = 16'hB1E5;
    for (int i = 15; i >= 1; i--) send_bit(sync_pat_i[i]);
    check(!in_sync_o, "R3", "16-bit before last bit", in_sync_o, 0);
    send_bit(sync_pat_i[0]);
    check(in_sync_o, "R3", "16-bit sync", in_sync_o, 1);
    send_char(8'h7E, 8, 1);

    // R3: length 1 acts as 2
    pulse_hunt();
    sync_len_i = 5'd1; sync_pat_i = 16'h0002;
    send_bit(0);
    check(!in_sync_o, "R3", "length 1 clamped to 2", in_sync_o, 0);
    send_bit(1); send_bit(0);
    check(in_sync_o, "R3", "2-bit sync", in_sync_o, 1);

    // R8 R10 R11: 16-bit CRC with a stripped sync mid-frame
    pulse_hunt();
    sync_len_i = 5'd8; sync_pat_i = 16'h0016; strip_en_i = 1'b1; crc32_sel_i = 1'b0;
    send_bit(1); send_bit(1); send_bit(1);
    send_sync(16'h0016, 8);
    check(in_sync_o, "R2", "sync for frame", in_sync_o, 1);
    pulse_blk();
    check(!crc_ok_o, "R10", "crc_ok after preset", crc_ok_o, 0);
    pick_frame(0, d, f);
    send_char(d[0], 8, 1); send_char(d[1], 8, 1);
    send_sync(16'h0016, 8);
    send_char(d[2], 8, 1); send_char(d[3], 8, 1);
    send_bytes(f);
    check(crc_ok_o, "R8", "16-bit residue, sync stripped (R11)", crc_ok_o, 1);

    // R11: without stripping the sync counts, so the old check bytes fail
    pulse_blk();
    strip_en_i = 1'b0;
    send_char(d[0], 8, 1); send_char(d[1], 8, 1);
    send_sync(16'h0016, 8); exp_q.push_back(8'h68);
    send_char(d[2], 8, 1); send_char(d[3], 8, 1);
    send_bytes(f);
    check(!crc_ok_o, "R11", "sync included in CRC", crc_ok_o, 0);
    pulse_blk();
    dm = {d[0], d[1], 8'h68, d[2], d[3]};
    fcs_of(dm, 0, f);
    send_bytes(dm);
    send_bytes(f);
    check(crc_ok_o, "R11", "CRC over data with sync", crc_ok_o, 1);

    // R9: 32-bit CRC
    pulse_blk();
    strip_en_i = 1'b1; crc32_sel_i = 1'b1;
    check(!crc_ok_o, "R10", "crc32 after preset", crc_ok_o, 0);
    pick_frame(1, d, f);
    send_bytes(d);
    check(!crc_ok_o, "R9", "no residue before check bytes", crc_ok_o, 0);
    send_bytes(f);
    check(crc_ok_o, "R9", "32-bit residue", crc_ok_o, 1);

    repeat (3) @(negedge clk_i);
    check(exp_q.size() == 0, "R5", "all characters delivered", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule